// File: doc/BRIEF.md
# Mode-Controlled Bit-Sliced ALU

This block is a combinational arithmetic/logic unit of parameterised width. It is built as a row of identical one-bit slices. Three controls choose the operation:

- A mode input picks between bitwise logic and arithmetic.
- One select conditionally complements operand A.
- A second select either passes operand B or forces it to zero.

A carry input feeds the least-significant slice. In arithmetic mode every slice is a full adder. Its three inputs are the possibly-inverted A bit, the gated B bit and the carry rippling up from the slice below.

In logic mode the carry chain is held at zero. Each slice then reduces to the exclusive-OR of its two conditioned operand bits. The same slice equation therefore covers both modes. The eight selections of each mode cover several operations:

- copies and complements of A;
- XOR and XNOR of A and B;
- sums of A and B;
- increment of A;
- two's complement negation of A;
- subtraction B minus A.

The unit is used as a datapath element. The surrounding logic presents operands and controls and reads the result within the same cycle. Besides the result, the unit reports the carry out of the top slice and a signed-overflow flag. The overflow flag is taken from the two top carries.

Top module: `modal_slice_alu`

## Requirements
- R1: With `arithMode`=0 and (`selUseB`,`selInvA`)=(0,0), `result` equals `opA`.
- R2: With `arithMode`=0 and (`selUseB`,`selInvA`)=(0,1), `result` equals the bitwise complement of `opA`.
- R3: With `arithMode`=0, the selection (1,0) gives `opA` XOR `opB` and the selection (1,1) gives `opA` XNOR `opB`.
- R4: With `arithMode`=0, `carryIn` has no effect on `result`, and `carryOut` and `overflow` are both 0.
- R5: With `arithMode`=1 and `carryIn`=0, `result` is one of the following, taken modulo 2^WIDTH:
  - selection (0,0): `opA`;
  - selection (0,1): NOT `opA`;
  - selection (1,0): `opA`+`opB`;
  - selection (1,1): NOT `opA` + `opB`.
- R6: With `arithMode`=1 and `carryIn`=1, `result` is one of the following, taken modulo 2^WIDTH:
  - selection (0,0): `opA`+1;
  - selection (0,1): the two's complement negation of `opA`;
  - selection (1,0): `opA`+`opB`+1;
  - selection (1,1): `opB`−`opA`.
- R7: With `arithMode`=1, `carryOut` is bit WIDTH of the unbounded sum of three terms: (`opA` XOR all-`selInvA`), (`opB` AND all-`selUseB`) and `carryIn`.
- R8: With `arithMode`=1, `overflow` is 1 exactly when the carry into the most significant slice differs from the carry out of it. This is the same as both adder operands sharing a sign bit while the result has the other sign.
- R9: With `selUseB`=0, `opB` has no effect on `result`, `carryOut` or `overflow` in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | Operand A |
| opB | input | WIDTH | Operand B |
| arithMode | input | 1 | 1 selects arithmetic, 0 selects bitwise logic |
| selUseB | input | 1 | 1 passes operand B into the slices, 0 forces it to zero |
| selInvA | input | 1 | 1 complements operand A before the slices |
| carryIn | input | 1 | Carry into the least-significant slice (arithmetic mode only) |
| result | output | WIDTH | Result word |
| carryOut | output | 1 | Carry out of the most-significant slice, 0 in logic mode |
| overflow | output | 1 | Signed overflow, 0 in logic mode |

## Verification
The hardest condition to reach is a carry that travels the whole chain. This happens only for operand pairs whose conditioned bits all propagate, such as an all-ones operand plus a carry-in, or all-ones added to one. The second hard condition is the pair of signed-overflow boundaries at the most positive and most negative values.

Random operands rarely produce either condition. The stimulus therefore crosses a fixed set of extremes with every mode, select and carry combination: zero, all ones, sign bit only, largest positive and one. Random pairs are added on top.

The claim that B is ignored is checked at the ports. The same A and controls are replayed with B inverted, and all outputs must stay unchanged.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  // Strobes that the control decoder hands to the slice datapath.
  typedef struct packed {
    logic invA;     // complement operand A in every slice
    logic gateB;    // let operand B into every slice
    logic carryEn;  // enable the carry chain (arithmetic)
  } sliceStrobes_t;

  typedef enum logic [1:0] {
    SEL_PASS_A = 2'b00,
    SEL_INV_A  = 2'b01,
    SEL_WITH_B = 2'b10,
    SEL_INVA_B = 2'b11
  } selCode_e;

endpackage

// File: rtl/alu_slice_ctrl.sv
module alu_slice_ctrl
  import alu_slice_pkg::*;
(
  input  logic          arithMode,
  input  logic          selUseB,
  input  logic          selInvA,
  output sliceStrobes_t strobes
);

  selCode_e selCode;

  assign selCode = selCode_e'({selUseB, selInvA});

  always_comb begin
    strobes.carryEn = arithMode;
    strobes.invA    = 1'b0;
    strobes.gateB   = 1'b0;
    unique case (selCode)
      SEL_PASS_A: begin strobes.invA = 1'b0; strobes.gateB = 1'b0; end
      SEL_INV_A:  begin strobes.invA = 1'b1; strobes.gateB = 1'b0; end
      SEL_WITH_B: begin strobes.invA = 1'b0; strobes.gateB = 1'b1; end
      SEL_INVA_B: begin strobes.invA = 1'b1; strobes.gateB = 1'b1; end
      default:    begin strobes.invA = 1'b0; strobes.gateB = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
  input  logic aBit,
  input  logic bBit,
  input  logic invA,
  input  logic gateB,
  input  logic carryEn,
  input  logic cIn,
  output logic fBit,
  output logic cOut
);

  logic aCond;
  logic bCond;

  assign aCond = aBit ^ invA;
  assign bCond = bBit & gateB;
  assign fBit  = aCond ^ bCond ^ cIn;
  assign cOut  = carryEn & ((aCond & bCond) | (cIn & (aCond ^ bCond)));

endmodule

// File: rtl/alu_slice_datapath.sv
module alu_slice_datapath
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  sliceStrobes_t    strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] chain;

  assign chain[0] = carryIn & strobes.carryEn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .aBit   (opA[i]),
      .bBit   (opB[i]),
      .invA   (strobes.invA),
      .gateB  (strobes.gateB),
      .carryEn(strobes.carryEn),
      .cIn    (chain[i]),
      .fBit   (result[i]),
      .cOut   (chain[i+1])
    );
  end

  assign carryOut = chain[WIDTH];
  assign overflow = strobes.carryEn & (chain[WIDTH] ^ chain[MSB]);

  // Word-level view used only by the checks below.
  logic [WIDTH-1:0] aWord;
  logic [WIDTH-1:0] bWord;
  logic [WIDTH:0]   wideSum;

  assign aWord   = opA ^ {WIDTH{strobes.invA}};
  assign bWord   = opB & {WIDTH{strobes.gateB}};
  assign wideSum = {1'b0, aWord} + {1'b0, bWord} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    if (!strobes.carryEn) begin
      p_chain_idle_r4: assert (chain == '0)
        else $error("carry chain active in logic mode");
      p_no_overflow_r4: assert (!overflow)
        else $error("overflow raised in logic mode");
      p_logic_word_r3: assert (result == (aWord ^ bWord))
        else $error("logic result mismatch");
    end else begin
      p_sum_word_r7: assert ({carryOut, result} == wideSum)
        else $error("ripple sum mismatch");
      p_overflow_sign_r8: assert (overflow ==
          ((aWord[MSB] == bWord[MSB]) && (result[MSB] != aWord[MSB])))
        else $error("overflow flag mismatch");
    end
  end

endmodule

// File: rtl/modal_slice_alu.sv
module modal_slice_alu
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             arithMode,
  input  logic             selUseB,
  input  logic             selInvA,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);

  sliceStrobes_t strobes;

  alu_slice_ctrl u_ctrl (
    .arithMode(arithMode),
    .selUseB  (selUseB),
    .selInvA  (selInvA),
    .strobes  (strobes)
  );

  alu_slice_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .strobes (strobes),
    .result  (result),
    .carryOut(carryOut),
    .overflow(overflow)
  );

endmodule

// File: tb/modal_slice_alu_tb.sv
module modal_slice_alu_tb;

  localparam int WIDTH      = 8;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_RAND   = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [WIDTH-1:0] opA, opB, result;
  logic arithMode, selUseB, selInvA, carryIn, carryOut, overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  modal_slice_alu #(.WIDTH(WIDTH)) u_dut (
    .opA(opA), .opB(opB), .arithMode(arithMode), .selUseB(selUseB),
    .selInvA(selInvA), .carryIn(carryIn), .result(result),
    .carryOut(carryOut), .overflow(overflow)
  );

  function automatic string resTag(logic m, logic s1, logic s0, logic c);
    if (!m) begin
      if (!s1 && !s0) return "R1";
      if (!s1 && s0)  return "R2";
      return "R3";
    end
    return c ? "R6" : "R5";
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (m=%0b s1=%0b s0=%0b c=%0b a=%0h b=%0h)",
               tag, act, exp, arithMode, selUseB, selInvA, carryIn, opA, opB);
    end
  endtask

  // Behavioural reference, integer arithmetic.
  task automatic applyAndCheck(logic m, logic s1, logic s0, logic c,
                               logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    longint mask, ea, eb, sum, expRes, expCo, expOv;
    mask = (longint'(1) << WIDTH) - 1;
    @(posedge clk);
    arithMode = m; selUseB = s1; selInvA = s0; carryIn = c; opA = a; opB = b;
    @(negedge clk);
    ea = s0 ? (~longint'(a)) & mask : longint'(a);
    eb = s1 ? longint'(b) : 0;
    if (m) begin
      sum    = ea + eb + longint'(c);
      expRes = sum & mask;
      expCo  = (sum >> WIDTH) & 1;
      expOv  = (((ea >> (WIDTH-1)) & 1) == ((eb >> (WIDTH-1)) & 1)) &&
               (((expRes >> (WIDTH-1)) & 1) != ((ea >> (WIDTH-1)) & 1)) ? 1 : 0;
      check(resTag(m, s1, s0, c), longint'(result), expRes);
      check("R7", longint'(carryOut), expCo);
      check("R8", longint'(overflow), expOv);
    end else begin
      expRes = ea ^ eb;
      check(resTag(m, s1, s0, c), longint'(result), expRes);
      check("R4", longint'(carryOut), 0);
      check("R4", longint'(overflow), 0);
    end
  endtask

  // B ignored when gated off: replay with inverted B, outputs must not move.
  task automatic checkBIgnored(logic m, logic s0, logic c,
                               logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    logic [WIDTH-1:0] r0;
    logic co0, ov0;
    @(posedge clk);
    arithMode = m; selUseB = 1'b0; selInvA = s0; carryIn = c; opA = a; opB = b;
    @(negedge clk);
    r0 = result; co0 = carryOut; ov0 = overflow;
    @(posedge clk);
    opB = ~b;
    @(negedge clk);
    check("R9", longint'(result), longint'(r0));
    check("R9", longint'(carryOut), longint'(co0));
    check("R9", longint'(overflow), longint'(ov0));
  endtask

  // Logic mode ignores carryIn (R4).
  task automatic checkCarryIgnored(logic s1, logic s0,
                                   logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    logic [WIDTH-1:0] r0;
    @(posedge clk);
    arithMode = 1'b0; selUseB = s1; selInvA = s0; carryIn = 1'b0; opA = a; opB = b;
    @(negedge clk);
    r0 = result;
    @(posedge clk);
    carryIn = 1'b1;
    @(negedge clk);
    check("R4", longint'(result), longint'(r0));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [WIDTH-1:0] corners [5];
    corners[0] = '0;
    corners[1] = '1;
    corners[2] = {1'b1, {(WIDTH-1){1'b0}}};
    corners[3] = {1'b0, {(WIDTH-1){1'b1}}};
    corners[4] = {{(WIDTH-1){1'b0}}, 1'b1};

    arithMode = 1'b0; selUseB = 1'b0; selInvA = 1'b0; carryIn = 1'b0;
    opA = '0; opB = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state with all-zero inputs.
    check("R1", longint'(result), 0);
    check("R4", longint'(carryOut), 0);
    check("R4", longint'(overflow), 0);

    for (int combo = 0; combo < 16; combo++) begin
      logic m, s1, s0, c;
      {m, s1, s0, c} = 4'(combo);
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          applyAndCheck(m, s1, s0, c, corners[i], corners[j]);
      for (int k = 0; k < NUM_RAND; k++)
        applyAndCheck(m, s1, s0, c, WIDTH'($urandom), WIDTH'($urandom));
    end

    for (int k = 0; k < 8; k++) begin
      logic [WIDTH-1:0] ra, rb;
      ra = (k < 5) ? corners[k] : WIDTH'($urandom);
      rb = WIDTH'($urandom);
      checkBIgnored(1'b1, k[0], k[1], ra, rb);
      checkBIgnored(1'b0, k[0], k[1], ra, rb);
      checkCarryIgnored(k[2], k[0], ra, rb);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule